// File: doc/BRIEF.md
# Two-Source Byte Shuffle Unit

This block rebuilds a 128-bit vector from the bytes of two 128-bit source vectors. In its general mode a third 128-bit operand, the control vector, names for every destination byte which of the 32 source bytes lands there. Any arrangement drawn from either source therefore takes a single operation.

Besides the general permute, two fixed shuffles are built in. Splat copies one element of the second source into every element of the result. Merge interleaves elements from the two sources. Both work on 8-, 16- or 32-bit elements, and merge takes either the upper or the lower half of each source. Each mode only produces a different select index per byte lane. One byte crossbar serves all modes.

An operation is presented together with `in_valid`. The result and `out_valid` appear from a register one clock later. Between operations the result register keeps its last value.

Top module: `vec_shuffle_unit`

## Requirements
- R1: While `rst_n` is low, and after release until the first accepted operation, `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` in each cycle equals `in_valid` of the previous cycle, so every accepted operation yields its result exactly one clock later.
- R3: With `op` = 0 (permute), byte i of `result` is byte k of the 32-byte string {`src_a`, `src_b`}, where k is the value of bits 4:0 of byte i of `ctrl`. Byte 0 of any vector is bits 127:120. Values 0 to 15 pick from `src_a` and values 16 to 31 pick from `src_b`.
- R4: In permute, bits 7:5 of each control byte have no effect on the result.
- R5: With `op` = 1 (splat), `esize` gives the element width: 0 means 8 bits, 1 means 16 bits and 2 means 32 bits. The element index `imm` is reduced modulo the element count. That element of `src_b` is copied into every element of `result`, with element 0 the most significant.
- R6: With `op` = 2 (merge high), result element 2j is element j of `src_a` and element 2j+1 is element j of `src_b`, for j over the upper (first) half of the elements.
- R7: With `op` = 3 (merge low), the same interleave is applied to the lower half, so result element 2j comes from element N/2+j of `src_a` and result element 2j+1 from element N/2+j of `src_b`. N is the element count.
- R8: `esize` = 3 behaves exactly as 32-bit elements.
- R9: In a cycle following one with `in_valid` low, `result` keeps its previous value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 2 | 0 permute, 1 splat, 2 merge high, 3 merge low |
| esize | input | 2 | Element width for splat and merge: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| imm | input | 4 | Splat element index |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| ctrl | input | 128 | Permute control vector, one select byte per lane |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 128 | Registered shuffled vector |

## Verification
The bench aims at the byte ordering. A design that numbered bytes from the least significant end would mirror every permute and merge, so both identity patterns and a sparse mixed pattern are compared byte by byte. A splat index larger than the element count must wrap. A design that failed to mask it would pick bytes of `src_a` or neighbouring data, so each element width is run with indices beyond range. Control bytes with their top three bits set, the reserved width code, and idle cycles with busy inputs catch a design that leaked upper control bits into the select, treated code 3 as a new width, or loaded the register without `in_valid`.

// File: rtl/vps_pkg.sv
package vps_pkg;
  localparam logic [1:0] OP_PERM = 2'd0;
  localparam logic [1:0] OP_SPLT = 2'd1;
  localparam logic [1:0] OP_MRGH = 2'd2;
  localparam logic [1:0] OP_MRGL = 2'd3;

  localparam logic [1:0] ES_8  = 2'd0;
  localparam logic [1:0] ES_16 = 2'd1;
  localparam logic [1:0] ES_32 = 2'd2;
endpackage

// File: rtl/vps_lane_sel.sv
// Per-lane select generator: turns the mode into a byte index 0..2*LANES-1
module vps_lane_sel
  import vps_pkg::*;
#(
  parameter int LANES = 16,
  parameter int LANE  = 0,
  localparam int LW   = $clog2(LANES),
  localparam int SW   = LW + 1
) (
  input  logic [1:0]    op,
  input  logic [1:0]    esize,
  input  logic [LW-1:0] imm,
  input  logic [7:0]    ctrl_byte,
  output logic [SW-1:0] sel
);
  localparam logic [LW-1:0] LANE_ID = LW'(LANE);
  localparam logic [LW-1:0] HALF    = LW'(LANES / 2);

  logic [1:0]    lg;
  logic [LW-1:0] off;
  logic [LW-1:0] elem;
  logic [LW-1:0] idx;
  logic [LW-1:0] half_base;
  logic [LW-1:0] src_elem;
  logic [LW-1:0] pick;
  logic          unused_ctrl_hi;

  assign unused_ctrl_hi = ^ctrl_byte[7:SW];

  always_comb begin
    // log2 of element size in bytes; code 3 folds onto 32-bit
    if (esize == ES_8)       lg = 2'd0;
    else if (esize == ES_16) lg = 2'd1;
    else                     lg = 2'd2;
    off       = LANE_ID & ~({LW{1'b1}} << lg);
    elem      = LANE_ID >> lg;
    idx       = imm & ({LW{1'b1}} >> lg);
    half_base = HALF >> lg;
    src_elem  = (elem >> 1) + ((op == OP_MRGL) ? half_base : '0);
    pick      = '0;
    sel       = '0;
    unique case (op)
      OP_PERM: sel = ctrl_byte[SW-1:0];
      OP_SPLT: begin
        pick = (idx << lg) | off;
        sel  = {1'b1, pick};
      end
      default: begin
        pick = (src_elem << lg) | off;
        sel  = {elem[0], pick};
      end
    endcase
  end
endmodule

// File: rtl/vps_byte_pick.sv
// One output lane of the crossbar: 2*LANES-to-1 byte selector
module vps_byte_pick #(
  parameter int LANES = 16,
  localparam int TOT  = 2 * LANES,
  localparam int SW   = $clog2(LANES) + 1
) (
  input  logic [TOT*8-1:0] pool,
  input  logic [SW-1:0]    sel,
  output logic [7:0]       byte_o
);
  always_comb begin
    byte_o = '0;
    for (int j = 0; j < TOT; j++) begin
      if (sel == SW'(j)) byte_o = pool[(TOT-1-j)*8 +: 8];
    end
  end
endmodule

// File: rtl/vec_shuffle_unit.sv
module vec_shuffle_unit
  import vps_pkg::*;
#(
  parameter int LANES = 16,
  localparam int VW   = LANES * 8,
  localparam int LW   = $clog2(LANES),
  localparam int SW   = LW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    op,
  input  logic [1:0]    esize,
  input  logic [LW-1:0] imm,
  input  logic [VW-1:0] src_a,
  input  logic [VW-1:0] src_b,
  input  logic [VW-1:0] ctrl,
  output logic          out_valid,
  output logic [VW-1:0] result
);
  logic [2*VW-1:0] pool;
  logic [SW-1:0]   lane_sel [LANES];
  logic [VW-1:0]   lane_byte;
  logic [VW-1:0]   res_d, res_q;
  logic            vld_d, vld_q;

  assign pool = {src_a, src_b};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    vps_lane_sel #(.LANES(LANES), .LANE(g)) u_sel (
      .op       (op),
      .esize    (esize),
      .imm      (imm),
      .ctrl_byte(ctrl[VW-1-8*g -: 8]),
      .sel      (lane_sel[g])
    );
    vps_byte_pick #(.LANES(LANES)) u_pick (
      .pool  (pool),
      .sel   (lane_sel[g]),
      .byte_o(lane_byte[VW-1-8*g -: 8])
    );
  end

  always_comb begin
    vld_d = in_valid;
    res_d = res_q;
    if (in_valid) res_d = lane_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
endmodule

// File: rtl/vps_chk.sv
module vps_chk
  import vps_pkg::*;
#(
  parameter int LANES = 16,
  localparam int VW   = LANES * 8,
  localparam int LW   = $clog2(LANES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [1:0]    op,
  input logic [1:0]    esize,
  input logic [LW-1:0] imm,
  input logic [VW-1:0] src_a,
  input logic [VW-1:0] src_b,
  input logic [VW-1:0] ctrl,
  input logic          out_valid,
  input logic [VW-1:0] result
);
  p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  p_splat_uniform_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_SPLT && esize == ES_8) |=> (result == {LANES{result[VW-1 -: 8]}}));
  p_merge_head_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_MRGH && esize == ES_8) |=>
      (result[VW-1 -: 8] == $past(src_a[VW-1 -: 8]) && result[VW-9 -: 8] == $past(src_b[VW-1 -: 8])));
  p_perm_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_PERM && ctrl == '0) |=> (result == {LANES{$past(src_a[VW-1 -: 8])}}));
endmodule

bind vec_shuffle_unit vps_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .esize(esize),
  .imm(imm), .src_a(src_a), .src_b(src_b), .ctrl(ctrl),
  .out_valid(out_valid), .result(result)
);

// File: tb/tb_vec_shuffle_unit.sv
`timescale 1ns/1ps
module tb_vec_shuffle_unit;
  import vps_pkg::*;

  logic         clk, rst_n, in_valid;
  logic [1:0]   op, esize;
  logic [3:0]   imm;
  logic [127:0] src_a, src_b, ctrl;
  logic         out_valid;
  logic [127:0] result;

  int checks = 0;
  int fails  = 0;
  logic [127:0] exp_res;
  logic [127:0] va, vb, vc;

  vec_shuffle_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .esize(esize),
    .imm(imm), .src_a(src_a), .src_b(src_b), .ctrl(ctrl),
    .out_valid(out_valid), .result(result)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] byte_of(logic [127:0] v, int n);
    return v[127-8*n -: 8];
  endfunction

  // behavioural model, element view
  function automatic logic [127:0] model(logic [1:0] o, logic [1:0] es, logic [3:0] im,
                                         logic [127:0] a, logic [127:0] b, logic [127:0] c);
    logic [127:0] r;
    int ebytes, nel, src_el;
    logic [7:0] cb;
    ebytes = (es == 2'd0) ? 1 : (es == 2'd1) ? 2 : 4;
    nel = 16 / ebytes;
    r = '0;
    for (int el = 0; el < nel; el++) begin
      for (int k = 0; k < ebytes; k++) begin
        int dst;
        dst = el * ebytes + k;
        case (o)
          OP_PERM: begin
            cb = byte_of(c, dst) % 32;
            r[127-8*dst -: 8] = (cb < 16) ? byte_of(a, cb) : byte_of(b, cb - 16);
          end
          OP_SPLT: r[127-8*dst -: 8] = byte_of(b, (im % nel) * ebytes + k);
          default: begin
            src_el = el / 2 + ((o == OP_MRGL) ? nel / 2 : 0);
            r[127-8*dst -: 8] = (el % 2 == 0) ? byte_of(a, src_el * ebytes + k)
                                              : byte_of(b, src_el * ebytes + k);
          end
        endcase
      end
    end
    return r;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic string tag_of(logic [1:0] o, logic [1:0] es);
    if (es == 2'd3) return "R8";
    case (o)
      OP_PERM: return "R3";
      OP_SPLT: return "R5";
      OP_MRGH: return "R6";
      default: return "R7";
    endcase
  endfunction

  // drive at a falling edge, compare at the next falling edge
  task automatic step(logic v, logic [1:0] o, logic [1:0] es, logic [3:0] im,
                      logic [127:0] a, logic [127:0] b, logic [127:0] c, string req);
    in_valid = v; op = o; esize = es; imm = im; src_a = a; src_b = b; ctrl = c;
    if (v) exp_res = model(o, es, im, a, b, c);
    @(negedge clk);
    check("R2", {127'd0, out_valid}, {127'd0, v});
    check(v ? req : "R9", result, exp_res);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = '0; esize = '0; imm = '0;
    src_a = '0; src_b = '0; ctrl = '0; exp_res = '0;
    for (int j = 0; j < 16; j++) begin
      va[127-8*j -: 8] = 8'hA0 + 8'(j);
      vb[127-8*j -: 8] = 8'hB0 + 8'(j);
    end
    repeat (3) @(negedge clk);
    in_valid = 1'b1; src_a = va;
    @(negedge clk);
    check("R1", {127'd0, out_valid}, 128'd0);
    check("R1", result, 128'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {127'd0, out_valid}, 128'd0);
    check("R1", result, 128'd0);

    // R3 identity from each source
    for (int j = 0; j < 16; j++) vc[127-8*j -: 8] = 8'(j);
    step(1, OP_PERM, 0, 0, va, vb, vc, "R3");
    check("R3", result, va);
    for (int j = 0; j < 16; j++) vc[127-8*j -: 8] = 8'(16 + j);
    step(1, OP_PERM, 0, 0, va, vb, vc, "R3");
    check("R3", result, vb);
    // R3 reversed across both, mixed pattern
    for (int j = 0; j < 16; j++) vc[127-8*j -: 8] = 8'(31 - 2 * j);
    step(1, OP_PERM, 0, 0, va, vb, vc, "R3");
    vc = {8'd3, 8'd1, 8'd20, 8'd17, 96'd0};
    step(1, OP_PERM, 0, 0, va, vb, vc, "R3");
    check("R3", result[127:96], {8'hA3, 8'hA1, 8'hB4, 8'hB1});
    // R4 upper control bits ignored
    for (int j = 0; j < 16; j++) vc[127-8*j -: 8] = 8'hE0 | 8'(j + 5);
    step(1, OP_PERM, 0, 0, va, vb, vc, "R4");
    check("R4", result[127:120], 8'hA5);
    // R9 idle cycles with busy inputs
    step(0, OP_SPLT, 1, 3, vb, va, ~vc, "R9");
    step(0, OP_PERM, 0, 0, '1, '1, '0, "R9");
    // R5 splat, in and out of range
    for (int es = 0; es < 3; es++) begin
      for (int im = 0; im < 16; im += 5) begin
        step(1, OP_SPLT, 2'(es), 4'(im), va, vb, vc, "R5");
      end
    end
    step(1, OP_SPLT, ES_16, 4'd9, va, vb, vc, "R5");
    check("R5", result, {8{8'hB2, 8'hB3}});
    // R6 and R7 merges for each width
    for (int es = 0; es < 3; es++) begin
      step(1, OP_MRGH, 2'(es), 0, va, vb, vc, "R6");
      step(1, OP_MRGL, 2'(es), 0, va, vb, vc, "R7");
    end
    step(1, OP_MRGL, ES_8, 0, va, vb, vc, "R7");
    check("R7", result[127:112], 16'hA8B8);
    // R8 code 3 equals 32-bit
    step(1, OP_MRGH, 2'd3, 0, va, vb, vc, "R8");
    check("R8", result, model(OP_MRGH, ES_32, 0, va, vb, vc));
    step(1, OP_SPLT, 2'd3, 4'd7, va, vb, vc, "R8");
    check("R8", result, {4{32'hBCBDBEBF}});
    // mixed random traffic, R2 and R9 interleaved
    for (int n = 0; n < 400; n++) begin
      logic [1:0] ro, re;
      logic [127:0] ra, rb, rc;
      ro = 2'($urandom); re = 2'($urandom);
      ra = {$urandom, $urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom, $urandom};
      rc = {$urandom, $urandom, $urandom, $urandom};
      step(($urandom % 4) != 0, ro, re, 4'($urandom), ra, rb, rc, tag_of(ro, re));
    end
    step(0, OP_PERM, 0, 0, '0, '0, '0, "R9");
    finish_run();
  end
endmodule